// File: doc/BRIEF.md
# Fault Address Capture Register

This block keeps the 64-bit virtual address that caused a synchronous fault taken to the most privileged level (level 3). On each exception-entry strobe it looks at the syndrome class, the fault-not-valid flag, whether the fault is an external abort, whether the source level ran in 32-bit state, and whether a data-cache maintenance instruction caused the fault. From these it decides whether to load a new address and what that address is. Two flags report how far the stored value can be trusted: one for the whole value and one for its top byte.

The same block decodes system-register move instructions. A read or a write names the register through five encoding fields. A privilege check turns any access from levels 0 to 2 into an undefined-instruction indication. The result of an access appears one cycle after its strobe.

An exception return from level 3, or execution at a lower level, makes the stored value unknown. The block models this by dropping the validity flags.

Top module: `fault_addr_capture`

## Requirements
- R1: On `exc_valid`, the register loads a new value only when `exc_class` is 0x20, 0x21, 0x22, 0x24 or 0x25. For any other class, `far_q` keeps its value and `far_valid` and `far_top_valid` read 0 after the edge.
- R2: After a capture, `far_valid` is 0 when `exc_ext_abort`=1, `exc_walk`=0 and `exc_fnv`=1. In every other capture case it is 1.
- R3: When `exc_src32`=1, bits [63:32] of the captured value are 0x00000000, or 0x00000001 when `exc_carry32`=1. Bits [31:0] come from the selected address.
- R4: When `exc_dc_maint`=1, the captured address is `exc_dc_operand` and not `exc_addr`.
- R5: An access hits the register only when op0=2'b11, op1=3'b110, CRn=4'b0110, CRm=4'b0000 and op2=3'b000. A write that hits at level 3 loads `acc_wdata` and sets both valid flags. An access that misses changes nothing and returns `rd_hit`=0, `rd_undef`=0 and `rd_data`=0.
- R6: A hitting access with `acc_el` below 3 returns `rd_undef`=1 and `rd_data`=0, and leaves `far_q` unchanged.
- R7: After a capture with `far_valid`=1, `far_top_valid` is 0 when `exc_ext_abort`=1, `exc_tbi`=1 and `exc_src32`=0. Otherwise it equals `far_valid`.
- R8: `exc_return` or `lower_exec` clears `far_valid` and `far_top_valid` when no capture and no level-3 write happens in the same cycle.
- R9: Reset sets `far_q` to zero and clears `far_valid`, `far_top_valid`, `rd_valid`, `rd_hit`, `rd_undef` and `rd_data`.
- R10: When `exc_valid` and a level-3 write fall in the same cycle, the exception wins and the write is dropped. A write wins over `exc_return` and `lower_exec`.
- R11: `rd_valid` is 1 exactly one cycle after `acc_valid`. A level-3 read returns the register value from before that edge. A write returns `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception-entry strobe |
| exc_class | input | 6 | Syndrome exception class |
| exc_fnv | input | 1 | Fault address not valid |
| exc_ext_abort | input | 1 | Fault is a synchronous external abort |
| exc_walk | input | 1 | External abort occurred on a table walk |
| exc_tbi | input | 1 | Top-byte-ignore enabled for the address |
| exc_src32 | input | 1 | Source level ran in 32-bit state |
| exc_carry32 | input | 1 | Access wrapped past 0xFFFFFFFF, setting bit 32 |
| exc_dc_maint | input | 1 | Fault came from a data-cache maintenance instruction |
| exc_addr | input | 64 | Faulting access address |
| exc_dc_operand | input | 64 | Register operand of the maintenance instruction |
| exc_return | input | 1 | Exception return from level 3 |
| lower_exec | input | 1 | Execution at a lower level |
| acc_valid | input | 1 | System-register access strobe |
| acc_write | input | 1 | 1 = write form, 0 = read form |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_el | input | 2 | Current privilege level |
| acc_wdata | input | 64 | Write data |
| far_q | output | 64 | Stored fault address |
| far_valid | output | 1 | Stored value is defined |
| far_top_valid | output | 1 | Bits [63:56] are defined |
| rd_valid | output | 1 | Access response strobe |
| rd_hit | output | 1 | Access matched this register |
| rd_undef | output | 1 | Access is undefined (privilege) |
| rd_data | output | 64 | Read data |

## Verification
A wrong class decode or a wrong validity calculation shows up on `far_valid` or `far_top_valid` one edge after the exception strobe. A bad upper-word or operand selection shows up on `far_q` at the same time. Faults in the privilege or encoding path appear on `rd_hit`, `rd_undef` and `rd_data` one cycle after the access strobe. A write that leaked through a denied access only surfaces later, at the next level-3 read. A reference model in the bench tracks the stored value and which of its bits are defined, and compares those bits on every cycle.

// File: rtl/fault_addr_capture.sv
module fault_addr_capture #(
  parameter int AW = 64,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_valid,
  input  logic [CW-1:0] exc_class,
  input  logic          exc_fnv,
  input  logic          exc_ext_abort,
  input  logic          exc_walk,
  input  logic          exc_tbi,
  input  logic          exc_src32,
  input  logic          exc_carry32,
  input  logic          exc_dc_maint,
  input  logic [AW-1:0] exc_addr,
  input  logic [AW-1:0] exc_dc_operand,
  input  logic          exc_return,
  input  logic          lower_exec,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_op0,
  input  logic [2:0]    acc_op1,
  input  logic [3:0]    acc_crn,
  input  logic [3:0]    acc_crm,
  input  logic [2:0]    acc_op2,
  input  logic [1:0]    acc_el,
  input  logic [AW-1:0] acc_wdata,
  output logic [AW-1:0] far_q,
  output logic          far_valid,
  output logic          far_top_valid,
  output logic          rd_valid,
  output logic          rd_hit,
  output logic          rd_undef,
  output logic [AW-1:0] rd_data
);
  localparam int HW = AW / 2;

  logic          cls_ok, hit, priv_ok, wr_ok, rd_ok, cap, fnv_bad, top_bad;
  logic [AW-1:0] src_addr, cap_val;

  assign cls_ok = (exc_class == CW'(6'h20)) || (exc_class == CW'(6'h21)) ||
                  (exc_class == CW'(6'h22)) || (exc_class == CW'(6'h24)) ||
                  (exc_class == CW'(6'h25));
  assign cap     = exc_valid && cls_ok;
  assign hit     = (acc_op0 == 2'b11) && (acc_op1 == 3'b110) && (acc_crn == 4'b0110) &&
                   (acc_crm == 4'b0000) && (acc_op2 == 3'b000);
  assign priv_ok = (acc_el == 2'd3);
  assign wr_ok   = acc_valid && hit && priv_ok && acc_write && !exc_valid;
  assign rd_ok   = acc_valid && hit && priv_ok && !acc_write;

  assign src_addr = exc_dc_maint ? exc_dc_operand : exc_addr;
  assign cap_val  = exc_src32 ? {HW'(exc_carry32), src_addr[HW-1:0]} : src_addr;
  assign fnv_bad  = exc_ext_abort && !exc_walk && exc_fnv;
  assign top_bad  = exc_ext_abort && exc_tbi && !exc_src32;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      far_q         <= '0;
      far_valid     <= 1'b0;
      far_top_valid <= 1'b0;
    end else if (exc_valid) begin
      if (cls_ok) begin
        far_q         <= cap_val;
        far_valid     <= !fnv_bad;
        far_top_valid <= !fnv_bad && !top_bad;
      end else begin
        far_valid     <= 1'b0;
        far_top_valid <= 1'b0;
      end
    end else if (wr_ok) begin
      far_q         <= acc_wdata;
      far_valid     <= 1'b1;
      far_top_valid <= 1'b1;
    end else if (exc_return || lower_exec) begin
      far_valid     <= 1'b0;
      far_top_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_hit   <= 1'b0;
      rd_undef <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid;
      rd_hit   <= acc_valid && hit;
      rd_undef <= acc_valid && hit && !priv_ok;
      rd_data  <= rd_ok ? far_q : '0;
    end
  end

  assert_ignore_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !cls_ok |=> $stable(far_q) && !far_valid && !far_top_valid);
  assert_fnv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap && exc_ext_abort && !exc_walk && exc_fnv |=> !far_valid);
  assert_upper_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap && exc_src32 |=> far_q[AW-1:HW+1] == '0);
  assert_top_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    far_top_valid |-> far_valid);
  assert_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && hit && !priv_ok |=> rd_undef && rd_data == '0);
  assert_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !priv_ok && !exc_valid |=> $stable(far_q));
  assert_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !hit |=> !rd_hit && !rd_undef && rd_data == '0);
  assert_invalidate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return || lower_exec) && !exc_valid && !wr_ok |=> !far_valid);
  assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && acc_valid && acc_write && !cls_ok |=> $stable(far_q));
  assert_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rd_valid);
  assert_noresp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rd_valid && !rd_hit && !rd_undef);
endmodule

// File: tb/test_fault_addr_capture.sv
module test_fault_addr_capture;
  logic        clk = 0, rst_n = 0;
  logic        exc_valid = 0, exc_fnv = 0, exc_ext_abort = 0, exc_walk = 0, exc_tbi = 0;
  logic        exc_src32 = 0, exc_carry32 = 0, exc_dc_maint = 0, exc_return = 0, lower_exec = 0;
  logic [5:0]  exc_class = 0;
  logic [63:0] exc_addr = 0, exc_dc_operand = 0, acc_wdata = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [1:0]  acc_op0 = 0, acc_el = 0;
  logic [2:0]  acc_op1 = 0, acc_op2 = 0;
  logic [3:0]  acc_crn = 0, acc_crm = 0;
  logic [63:0] far_q, rd_data;
  logic        far_valid, far_top_valid, rd_valid, rd_hit, rd_undef;

  int checks = 0, fails = 0;
  logic [63:0] m_far = 0;
  logic        m_v = 0, m_t = 0;
  logic        e_rv, e_hit, e_und, e_dchk, e_dtop;
  logic [63:0] e_data;

  always #2.5 clk = ~clk;

  fault_addr_capture i_fault_addr_capture (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit cls_ok(input logic [5:0] c);
    return c == 6'h20 || c == 6'h21 || c == 6'h22 || c == 6'h24 || c == 6'h25;
  endfunction

  function automatic bit enc_hit();
    return acc_op0 == 2'b11 && acc_op1 == 3'b110 && acc_crn == 4'b0110 &&
           acc_crm == 4'b0000 && acc_op2 == 3'b000;
  endfunction

  function automatic logic [63:0] cap_value();
    logic [63:0] a = exc_dc_maint ? exc_dc_operand : exc_addr;
    if (exc_src32) return {31'b0, exc_carry32, a[31:0]};
    return a;
  endfunction

  task automatic clear_inputs();
    exc_valid = 0; exc_fnv = 0; exc_ext_abort = 0; exc_walk = 0; exc_tbi = 0;
    exc_src32 = 0; exc_carry32 = 0; exc_dc_maint = 0; exc_return = 0; lower_exec = 0;
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic set_enc();
    acc_op0 = 2'b11; acc_op1 = 3'b110; acc_crn = 4'b0110; acc_crm = 4'b0000; acc_op2 = 3'b000;
  endtask

  task automatic step(input string req);
    logic [63:0] nf = m_far;
    logic nv = m_v, nt = m_t;
    bit h = enc_hit();
    e_rv = acc_valid; e_hit = acc_valid && h; e_und = acc_valid && h && acc_el != 3;
    e_dchk = 1; e_dtop = 1; e_data = 0;
    if (acc_valid && h && acc_el == 3 && !acc_write) begin
      e_data = m_far; e_dchk = m_v; e_dtop = m_t;
    end
    if (exc_valid) begin
      if (cls_ok(exc_class)) begin
        nf = cap_value();
        nv = !(exc_ext_abort && !exc_walk && exc_fnv);
        nt = nv && !(exc_ext_abort && exc_tbi && !exc_src32);
      end else begin nv = 0; nt = 0; end
    end else if (acc_valid && h && acc_write && acc_el == 3) begin
      nf = acc_wdata; nv = 1; nt = 1;
    end else if (exc_return || lower_exec) begin nv = 0; nt = 0; end
    @(posedge clk); #1;
    m_far = nf; m_v = nv; m_t = nt;
    chk(far_valid === m_v, {req, " far_valid"}, 64'(far_valid), 64'(m_v));
    chk(far_top_valid === m_t, {req, " far_top_valid"}, 64'(far_top_valid), 64'(m_t));
    if (m_v) begin
      chk(far_q[55:0] === m_far[55:0], {req, " far_q low"}, far_q, m_far);
      if (m_t) chk(far_q[63:56] === m_far[63:56], {req, " far_q top"}, far_q, m_far);
    end
    chk(rd_valid === e_rv, "R11 rd_valid", 64'(rd_valid), 64'(e_rv));
    chk(rd_hit === e_hit, "R5 rd_hit", 64'(rd_hit), 64'(e_hit));
    chk(rd_undef === e_und, "R6 rd_undef", 64'(rd_undef), 64'(e_und));
    if (e_dchk) begin
      if (e_dtop) chk(rd_data === e_data, "R11 rd_data", rd_data, e_data);
      else chk(rd_data[55:0] === e_data[55:0], "R11 rd_data low", rd_data, e_data);
    end
    clear_inputs();
  endtask

  initial begin
    #50000;
    fails++; checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(far_q === 0 && !far_valid && !far_top_valid, "R9 reset state", far_q, 0);
    chk(!rd_valid && !rd_hit && !rd_undef && rd_data === 0, "R9 reset resp", rd_data, 0);

    // R3: 32-bit source with carry into bit 32
    exc_valid = 1; exc_class = 6'h24; exc_src32 = 1; exc_carry32 = 1;
    exc_addr = 64'hDEAD_BEEF_0000_0004; step("R3 carry");
    chk(far_q === 64'h0000_0001_0000_0004, "R3 upper word", far_q, 64'h0000_0001_0000_0004);
    // R4: cache maintenance operand
    exc_valid = 1; exc_class = 6'h25; exc_dc_maint = 1; exc_addr = 64'h1111;
    exc_dc_operand = 64'h0123_4567_89AB_CDEF; step("R4 dc operand");
    chk(far_q === 64'h0123_4567_89AB_CDEF, "R4 operand", far_q, 64'h0123_4567_89AB_CDEF);
    // R1: class not in set
    exc_valid = 1; exc_class = 6'h15; exc_addr = 64'h5555; step("R1 other class");
    // R2: fault-not-valid on external abort
    exc_valid = 1; exc_class = 6'h20; exc_ext_abort = 1; exc_fnv = 1; exc_addr = 64'h77; step("R2 fnv");
    // R7: top byte ignore
    exc_valid = 1; exc_class = 6'h21; exc_ext_abort = 1; exc_tbi = 1; exc_addr = 64'hAB00_0000_0000_1000; step("R7 tbi");
    // R6: low-level write refused, then level-3 read exposes unchanged value
    set_enc(); acc_valid = 1; acc_write = 1; acc_el = 1; acc_wdata = 64'hFFFF; step("R6 low write");
    set_enc(); acc_valid = 1; acc_el = 3; step("R6 readback");
    // R10: exception and write together
    exc_valid = 1; exc_class = 6'h22; exc_addr = 64'h42;
    set_enc(); acc_valid = 1; acc_write = 1; acc_el = 3; acc_wdata = 64'h99; step("R10 priority");
    chk(far_q === 64'h42, "R10 capture wins", far_q, 64'h42);
    // R5: encoding miss write at level 3
    set_enc(); acc_crm = 4'b0001; acc_valid = 1; acc_write = 1; acc_el = 3; acc_wdata = 64'h5; step("R5 miss");
    // R8: invalidation
    exc_return = 1; step("R8 eret");
    set_enc(); acc_valid = 1; acc_write = 1; acc_el = 3; acc_wdata = 64'hCAFE; step("R5 write");
    lower_exec = 1; step("R8 lower exec");

    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 5);
      exc_valid = ($urandom_range(0, 9) < 3);
      exc_class = (k < 5) ? 6'h20 + 6'(k == 4 ? 5 : k) : 6'($urandom);
      {exc_fnv, exc_ext_abort, exc_walk, exc_tbi, exc_src32, exc_carry32, exc_dc_maint} = 7'($urandom);
      exc_addr = {$urandom, $urandom}; exc_dc_operand = {$urandom, $urandom};
      exc_return = ($urandom_range(0, 19) == 0); lower_exec = ($urandom_range(0, 19) == 0);
      acc_valid = ($urandom_range(0, 9) < 4); acc_write = $urandom_range(0, 1);
      acc_el = 2'($urandom); acc_wdata = {$urandom, $urandom};
      set_enc();
      if ($urandom_range(0, 3) == 0) acc_op1 = 3'($urandom);
      if ($urandom_range(0, 7) == 0) acc_crn = 4'($urandom);
      step("R1 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule